// File: doc/BRIEF.md
# Unsigned Arithmetic and Logic Unit with Condition Flags

This block is the purely combinational datapath core of a small 16-bit machine that works only with whole numbers. The decode stage presents a 5-bit operation code, two register operands and an 8-bit immediate. In the same cycle the block returns a primary result, a secondary result that only division uses, a strobe saying whether the primary result should be written back, and the complete next value of the machine's condition-flag word.

Arithmetic treats every value as unsigned. Subtraction that would go below zero saturates at zero and raises the overflow flag. Division delivers quotient and remainder together, so the register file can write both in one step. Every operation that does not define the flags returns an all-zero flag word. The caller therefore writes the flag word back unconditionally on every instruction. Single-operand operations (shifts and bitwise inversion) take their source from operand A.

Top module: `ualu_core`

## Requirements
- R1: Opcode 00000 (add) gives result = (A + B) mod 65536. Flag bit 3 (overflow) is 1 exactly when A + B exceeds 65535. The truncated sum is presented even on overflow.
- R2: Opcode 00001 (subtract) gives A − B with bit 3 clear when A ≥ B. When B > A it gives 0 with bit 3 set.
- R3: Opcode 00110 (multiply) gives the low 16 bits of A × B. Bit 3 is set exactly when the full product exceeds 65535.
- R4: Opcode 00111 (divide) with B ≠ 0 gives floor(A / B) on the primary result and A mod B on the secondary result, with all flags clear.
- R5: Opcode 00111 with B = 0 gives 0 on both results and sets bit 3.
- R6: Opcode 01000 shifts A right by the immediate with zero fill. Opcode 01001 shifts A left by the immediate. A shift amount of 16 or more gives 0. Both return all-zero flags.
- R7: Opcodes 01010, 01011 and 01100 give A XOR B, A OR B and A AND B. Opcode 01101 gives NOT A. All four return all-zero flags.
- R8: Opcode 01110 (compare) drives the primary result to 0 and the write strobe low. It sets exactly one of bit 2 (A < B), bit 1 (A > B) or bit 0 (A = B).
- R9: Flag bits 15 to 4 are always 0. The secondary result is 0 for every opcode other than divide.
- R10: Any opcode not listed in R1 to R8 gives a zero result, a zero secondary result, all-zero flags and the write strobe low.
- R11: The write strobe is high for every opcode in R1 to R7 and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| opnd_a_i | input | 16 | First operand; sole source for shifts and NOT |
| opnd_b_i | input | 16 | Second operand |
| imm_i | input | 8 | Unsigned shift amount |
| result_o | output | 16 | Primary result (quotient for divide) |
| aux_o | output | 16 | Secondary result (remainder for divide) |
| wr_valid_o | output | 1 | Primary result is to be written back |
| flags_o | output | 16 | Next condition-flag word |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They take for granted that all four inputs are two-valued and change together, so the checker never sees a mix of an old opcode and new operands. The bench meets this by driving every input in one step on the falling clock edge and holding it until after the outputs are sampled. The operand sweep draws on a fixed set of boundary values (0, 1, powers of two and all-ones patterns) so that every carry, borrow and product-overflow edge lands in the stimulus.

// File: rtl/ualu_pkg.sv
// Shared definitions for the unsigned ALU: operation codes and flag bit positions.
// Assumes a 5-bit operation code; flag positions are fixed by the machine's flag word.
package ualu_pkg;

    localparam int OP_W = 5;

    localparam int FLAG_EQ  = 0;
    localparam int FLAG_GT  = 1;
    localparam int FLAG_LT  = 2;
    localparam int FLAG_OVF = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'b00000,
        OP_SUB  = 5'b00001,
        OP_MUL  = 5'b00110,
        OP_DIV  = 5'b00111,
        OP_SHR  = 5'b01000,
        OP_SHL  = 5'b01001,
        OP_XOR  = 5'b01010,
        OP_OR   = 5'b01011,
        OP_AND  = 5'b01100,
        OP_NOT  = 5'b01101,
        OP_CMP  = 5'b01110
    } alu_op_e;

endpackage

// File: rtl/ualu_arith.sv
// Add, saturating subtract and multiply on unsigned operands.
// Assumes unsigned inputs; each result comes with its own overflow indication.
module ualu_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         sum_ovf_o,
    output logic [W-1:0] diff_o,
    output logic         diff_ovf_o,
    output logic [W-1:0] prod_o,
    output logic         prod_ovf_o
);
    localparam int PW = 2 * W;

    logic [W:0]    sum_full;
    logic [PW-1:0] prod_full;
    logic          borrow;

    // Sum with carry-out kept for the overflow test.
    always_comb begin
        sum_full  = {1'b0, a_i} + {1'b0, b_i};
        sum_o     = sum_full[W-1:0];
        sum_ovf_o = sum_full[W];
    end

    // Subtract that clamps at zero when the subtrahend is larger.
    always_comb begin
        borrow     = b_i > a_i;
        diff_o     = borrow ? '0 : a_i - b_i;
        diff_ovf_o = borrow;
    end

    // Full-width product; any set upper bit means overflow.
    always_comb begin
        prod_full  = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        prod_o     = prod_full[W-1:0];
        prod_ovf_o = |prod_full[PW-1:W];
    end
endmodule

// File: rtl/ualu_divider.sv
// Combinational restoring divider producing quotient and remainder together.
// Assumes unsigned operands; a zero divisor yields zero for both and raises div_zero_o.
module ualu_divider #(
    parameter int W = 16
) (
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         div_zero_o
);
    logic [W-1:0] part_rem [W+1];
    logic [W-1:0] quot_raw;

    assign part_rem[0] = '0;

    // One restoring step per quotient bit, most significant first.
    for (genvar i = 0; i < W; i++) begin : g_step
        localparam int K = W - 1 - i;
        logic [W:0] trial;
        logic       fits;
        assign trial        = {part_rem[i], dividend_i[K]};
        assign fits         = trial >= {1'b0, divisor_i};
        assign quot_raw[K]  = fits;
        assign part_rem[i+1] = fits ? W'(trial - {1'b0, divisor_i}) : trial[W-1:0];
    end

    // Zero divisor overrides both outputs.
    always_comb begin
        div_zero_o = divisor_i == '0;
        quot_o     = div_zero_o ? '0 : quot_raw;
        rem_o      = div_zero_o ? '0 : part_rem[W];
    end
endmodule

// File: rtl/ualu_shift.sv
// Logical shifts of one operand by an unsigned immediate amount.
// Assumes amounts at or beyond the word width clear the result.
module ualu_shift #(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  logic [W-1:0]     a_i,
    input  logic [IMM_W-1:0] amt_i,
    output logic [W-1:0]     shr_o,
    output logic [W-1:0]     shl_o
);
    logic too_far;

    // Zero-filling shifts with an explicit out-of-range guard.
    always_comb begin
        too_far = int'(amt_i) >= W;
        shr_o   = too_far ? '0 : a_i >> amt_i;
        shl_o   = too_far ? '0 : a_i << amt_i;
    end
endmodule

// File: rtl/ualu_logic.sv
// Bitwise XOR, OR, AND and inversion.
// Assumes inversion acts on operand A only.
module ualu_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] and_o,
    output logic [W-1:0] not_o
);
    // All four bitwise results in parallel.
    always_comb begin
        xor_o = a_i ^ b_i;
        or_o  = a_i | b_i;
        and_o = a_i & b_i;
        not_o = ~a_i;
    end
endmodule

// File: rtl/ualu_core.sv
// Top of the unsigned ALU: selects one unit's result by opcode and builds the flag word.
// Assumes purely combinational use; flags not defined by an operation are returned as zero.
module ualu_core #(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  logic [ualu_pkg::OP_W-1:0] op_i,
    input  logic [W-1:0]              opnd_a_i,
    input  logic [W-1:0]              opnd_b_i,
    input  logic [IMM_W-1:0]          imm_i,
    output logic [W-1:0]              result_o,
    output logic [W-1:0]              aux_o,
    output logic                      wr_valid_o,
    output logic [W-1:0]              flags_o
);
    import ualu_pkg::*;

    alu_op_e      op;
    logic [W-1:0] sum, diff, prod, quot, rem, shr, shl, vx, vo, va, vn;
    logic         sum_ovf, diff_ovf, prod_ovf, div_zero;

    assign op = alu_op_e'(op_i);

    ualu_arith #(.W(W)) u_arith (
        .a_i(opnd_a_i), .b_i(opnd_b_i),
        .sum_o(sum), .sum_ovf_o(sum_ovf),
        .diff_o(diff), .diff_ovf_o(diff_ovf),
        .prod_o(prod), .prod_ovf_o(prod_ovf)
    );

    ualu_divider #(.W(W)) u_div (
        .dividend_i(opnd_a_i), .divisor_i(opnd_b_i),
        .quot_o(quot), .rem_o(rem), .div_zero_o(div_zero)
    );

    ualu_shift #(.W(W), .IMM_W(IMM_W)) u_shift (
        .a_i(opnd_a_i), .amt_i(imm_i), .shr_o(shr), .shl_o(shl)
    );

    ualu_logic #(.W(W)) u_logic (
        .a_i(opnd_a_i), .b_i(opnd_b_i),
        .xor_o(vx), .or_o(vo), .and_o(va), .not_o(vn)
    );

    // Opcode-driven selection of results, write strobe and flag word.
    always_comb begin
        result_o   = '0;
        aux_o      = '0;
        wr_valid_o = 1'b1;
        flags_o    = '0;
        unique case (op)
            OP_ADD: begin result_o = sum;  flags_o[FLAG_OVF] = sum_ovf;  end
            OP_SUB: begin result_o = diff; flags_o[FLAG_OVF] = diff_ovf; end
            OP_MUL: begin result_o = prod; flags_o[FLAG_OVF] = prod_ovf; end
            OP_DIV: begin
                result_o           = quot;
                aux_o              = rem;
                flags_o[FLAG_OVF]  = div_zero;
            end
            OP_SHR: result_o = shr;
            OP_SHL: result_o = shl;
            OP_XOR: result_o = vx;
            OP_OR:  result_o = vo;
            OP_AND: result_o = va;
            OP_NOT: result_o = vn;
            OP_CMP: begin
                wr_valid_o       = 1'b0;
                flags_o[FLAG_LT] = opnd_a_i < opnd_b_i;
                flags_o[FLAG_GT] = opnd_a_i > opnd_b_i;
                flags_o[FLAG_EQ] = opnd_a_i == opnd_b_i;
            end
            default: wr_valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ualu_core_chk.sv
// Checker for the unsigned ALU: immediate checks relating ports whenever inputs change.
// Assumes two-valued inputs that change together.
module ualu_core_chk #(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input logic [ualu_pkg::OP_W-1:0] op_i,
    input logic [W-1:0]              opnd_a_i,
    input logic [W-1:0]              opnd_b_i,
    input logic [IMM_W-1:0]          imm_i,
    input logic [W-1:0]              result_o,
    input logic [W-1:0]              aux_o,
    input logic                      wr_valid_o,
    input logic [W-1:0]              flags_o
);
    import ualu_pkg::*;

    logic [W:0]     wide_sum;
    logic [2*W-1:0] recomb;

    // Port-level consistency checks per operation.
    always_comb begin
        wide_sum = {1'b0, opnd_a_i} + {1'b0, opnd_b_i};
        recomb   = {{W{1'b0}}, result_o} * {{W{1'b0}}, opnd_b_i} + {{W{1'b0}}, aux_o};
        // R9
        flags_high_zero_chk: assert (flags_o[W-1:4] == '0);
        if (op_i == OP_ADD) begin
            // R1
            add_wrap_chk: assert ({flags_o[FLAG_OVF], result_o} == wide_sum);
        end
        if (op_i == OP_SUB && opnd_b_i > opnd_a_i) begin
            // R2
            sub_clamp_chk: assert (result_o == '0 && flags_o[FLAG_OVF]);
        end
        if (op_i == OP_DIV && opnd_b_i != '0) begin
            // R4
            div_recombine_chk: assert (recomb == {{W{1'b0}}, opnd_a_i} && aux_o < opnd_b_i);
        end
        if (op_i == OP_CMP) begin
            // R8
            cmp_onehot_chk: assert ($onehot(flags_o[2:0]) && !wr_valid_o && flags_o[FLAG_OVF] == 1'b0);
        end
        if (op_i != OP_DIV) begin
            // R9
            aux_idle_chk: assert (aux_o == '0);
        end
    end
endmodule

bind ualu_core ualu_core_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
    .op_i(op_i), .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .imm_i(imm_i),
    .result_o(result_o), .aux_o(aux_o), .wr_valid_o(wr_valid_o), .flags_o(flags_o)
);

// File: tb/tb_ualu_core.sv
// Sweep bench: every opcode over a boundary operand set, plus a full shift-amount sweep.
module tb_ualu_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic [4:0]  op;
    logic [15:0] a, b;
    logic [7:0]  imm;
    logic [15:0] res, aux, flags;
    logic        wv;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ualu_core dut (
        .op_i(op), .opnd_a_i(a), .opnd_b_i(b), .imm_i(imm),
        .result_o(res), .aux_o(aux), .wr_valid_o(wv), .flags_o(flags)
    );

    function automatic string tag_of(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            6: return "R3";
            7: return "R4";
            8, 9: return "R6";
            10, 11, 12, 13: return "R7";
            14: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string t, input longint act, input longint exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s op=%b a=%h b=%h imm=%0d actual=%h expected=%h",
                     t, what, op, a, b, imm, act, exp);
        end
    endtask

    task automatic run(input int o, input int va, input int vb, input int vi);
        longint s, e_res, e_aux, e_flg;
        bit     e_wv;
        string  t;
        @(negedge clk);
        op = 5'(o); a = 16'(va); b = 16'(vb); imm = 8'(vi);
        e_res = 0; e_aux = 0; e_flg = 0; e_wv = 1;
        t = tag_of(o);
        case (o)
            0: begin s = va + vb; e_res = s % 65536; e_flg = (s > 65535) ? 8 : 0; end
            1: begin if (vb > va) begin e_res = 0; e_flg = 8; end else e_res = va - vb; end
            6: begin s = longint'(va) * vb; e_res = s % 65536; e_flg = (s > 65535) ? 8 : 0; end
            7: begin
                if (vb == 0) begin e_flg = 8; t = "R5"; end
                else begin e_res = va / vb; e_aux = va % vb; end
            end
            8: e_res = (vi >= 16) ? 0 : (va >> vi);
            9: e_res = (vi >= 16) ? 0 : ((va << vi) % 65536);
            10: e_res = va ^ vb;
            11: e_res = va | vb;
            12: e_res = va & vb;
            13: e_res = 65535 - va;
            14: begin e_wv = 0; e_flg = (va < vb) ? 4 : (va > vb) ? 2 : 1; end
            default: e_wv = 0;
        endcase
        #(CLK_PERIOD/4);
        chk(t, res, e_res, "result");
        chk(t, flags[3:0], e_flg, "flags");
        chk((o == 7) ? t : "R9", {aux, flags[15:4]}, {e_aux[15:0], 12'h000}, "aux/flags-high");
        chk((o == 14) ? "R8" : (e_wv ? "R11" : "R10"), wv, e_wv, "write strobe");
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        int vals [12] = '{0, 1, 2, 3, 255, 256, 4660, 32767, 32768, 43981, 65534, 65535};
        int amts [7]  = '{0, 1, 7, 15, 16, 17, 255};
        op = '0; a = '0; b = '0; imm = '0;
        // Idle state with all-zero inputs: add of zeros, R1.
        #(CLK_PERIOD/2);
        chk("R1", res, 0, "idle result");
        chk("R11", wv, 1, "idle strobe");
        // Every opcode, every operand pair: R1-type coverage of all tags.
        for (int o = 0; o < 32; o++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    run(o, vals[i], vals[j], amts[(i + j) % 7]);
        // Full shift-amount sweep for both shift directions, R6.
        for (int o = 8; o < 10; o++)
            for (int i = 0; i < 12; i++)
                for (int k = 0; k < 256; k++)
                    run(o, vals[i], vals[11 - i], k);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule